// File: doc/BRIEF.md
# Wake-up Line and Stop-Entry Controller

This block watches sixteen external wake-up lines and an NMI input on behalf of a processor. Each line can be enabled or disabled on its own, and each line detects either a rising or a falling edge. An enabled line's edge sets a pending flag, and the pending flags drive an interrupt request. A mode bit decides whether line edges may also bring the chip back out of a low-power stop state. The block never gates clocks itself. It drives a stop-request level that the clock and power logic acts on, and a one-cycle wake pulse when the stop state ends.

Stop entry is guarded. Software must write the stop bit of the control register three times in a row with the values 1, 0, 1. An interrupt/DMA acknowledge, or a write to any other register, in the middle of these writes cancels the attempt. Two readable flags, the stop flag and the exit flag, then tell software what happened. Both 0 means stop was never entered. Stop flag 0 with exit flag 1 means a wake line ended stop. Both 1 means an NMI rising edge ended stop.

The sequence tracker has four states. `ST_RUN` is normal operation. `ST_ARM1` is entered from `ST_RUN` on a control write with stop=1 ("first-one"). `ST_ARM10` is entered from `ST_ARM1` on a control write with stop=0 ("zero"). `ST_STOPPED` is entered from `ST_ARM10` on a control write with stop=1 ("commit"). The armed states fall back to `ST_RUN` on an acknowledge or on a write to another register ("abort"). `ST_ARM10` also falls back on a second stop=0 write ("bad-order"). `ST_ARM1` stays in `ST_ARM1` on a repeated stop=1 write ("restart"). `ST_STOPPED` returns to `ST_RUN` on an NMI rising edge ("nmi-exit") or, in wake mode, on an enabled line edge ("line-exit").

Register map (3-bit address, 8-bit data):

| Address | Register | Access |
|---|---|---|
| 0 | Enable mask, lines 7..0 | read/write |
| 1 | Enable mask, lines 15..8 | read/write |
| 2 | Edge select, lines 7..0 | read/write |
| 3 | Edge select, lines 15..8 | read/write |
| 4 | Pending flags, lines 7..0 | read, write 1 to clear |
| 5 | Pending flags, lines 15..8 | read, write 1 to clear |
| 6 | Control | see below |

Control register bits:

| Bit | Name | Meaning |
|---|---|---|
| 0 | wake mode | 1 lets line edges end stop |
| 1 | interrupt enable | 1 lets pending flags reach `irq_o` |
| 2 | stop | write feeds the sequence; read returns the stop flag |
| 3 | exit | write 0 clears the exit flag; read returns the exit flag |

Top module: `wkup_stop_ctrl`

## Requirements
- R1: After reset every register reads 0, and `irq_o`, `stop_req_o` and `wake_o` are 0.
- R2: A line whose enable bit is 0 never sets its pending flag, whatever edges it sees.
- R3: Edge-select bit 1 picks a rising edge and bit 0 picks a falling edge. Only the selected edge sets the pending flag of an enabled line. The flag is set on the third rising clock edge after the input changes, and each edge sets it once.
- R4: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. If a new edge and a clearing write land in the same cycle, the flag stays set.
- R5: `irq_o` is 1 exactly when the interrupt enable (control bit 1) is 1 and at least one line has both its pending flag and its enable bit set.
- R6: Three control writes with stop bit values 1, 0, 1, with no other write between them, raise `stop_req_o` from the clock edge of the third write. The stop flag then reads 1.
- R7: An acknowledge pulse, or a write to a non-control address, between the writes of the sequence cancels it. `stop_req_o` stays 0, and the stop and exit flags read 0.
- R8: Any other order of stop bit values, such as 1, 0, 0, 1, does not raise `stop_req_o`.
- R9: In wake mode (control bit 0 = 1), an enabled line edge during stop drops `stop_req_o`, gives a `wake_o` pulse exactly one cycle long, and leaves stop flag 0 and exit flag 1.
- R10: An NMI rising edge during stop drops `stop_req_o` on the next clock edge and leaves stop flag 1 and exit flag 1. The stop flag stays 1 until a control write with stop bit 0.
- R11: With wake mode 0, line edges during stop set pending flags but do not end stop.
- R12: The exit flag is cleared by a control write with bit 3 = 0, or by the commit of a new stop sequence even if that sequence writes bit 3 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data at `addr` (combinational) |
| lines_i | input | 16 | Asynchronous wake-up lines |
| nmi_i | input | 1 | Non-maskable event input, synchronous to `clk` |
| ack_i | input | 1 | Interrupt/DMA acknowledge strobe |
| irq_o | output | 1 | Interrupt request |
| stop_req_o | output | 1 | High while the stop state is held |
| wake_o | output | 1 | One-cycle pulse when the stop state ends |

## Verification
A tracker stuck in an armed state shows up at once as a wrong `stop_req_o` level after the next control write. A lost transition shows up as a stop request after a sequence that should have been cancelled. A corrupted stop or exit flag is visible on the very next read of the control register, so each exit path is followed by an immediate read. Edge-detector faults appear three cycles after an input change, either as a pending flag that was expected and is missing or as one that appears without a cause, and as a wake pulse that lasts zero or two cycles.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
    localparam int unsigned BANK_W = 8;
    localparam int CB_MODE  = 0;
    localparam int CB_IRQEN = 1;
    localparam int CB_STOP  = 2;
    localparam int CB_EXIT  = 3;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_ARM1,
        ST_ARM10,
        ST_STOPPED
    } seq_state_t;
endpackage

// File: rtl/wkup_line_edge.sv
module wkup_line_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic rise_sel_i,
    output logic edge_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              cur;

    assign cur = sync_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], line_i};
            prev_q <= cur;
        end
    end

    assign edge_o = rise_sel_i ? (cur & ~prev_q) : (~cur & prev_q);
endmodule

// File: rtl/wkup_stop_fsm.sv
module wkup_stop_fsm
    import wkup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic other_wr,
    input  logic stop_wbit,
    input  logic exit_wbit,
    input  logic ack_i,
    input  logic nmi_i,
    input  logic line_wake,
    output logic stop_req_o,
    output logic wake_o,
    output logic stop_flag_o,
    output logic exit_flag_o
);
    seq_state_t st, nxt;
    logic nmi_q, nmi_rise, enter, leave;
    logic stop_q, exit_q, wake_q;

    assign nmi_rise = nmi_i & ~nmi_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_RUN;
            nmi_q <= 1'b0;
        end else begin
            st    <= nxt;
            nmi_q <= nmi_i;
        end
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_RUN: begin
                if (ctrl_wr && !ack_i && stop_wbit) nxt = ST_ARM1;
            end
            ST_ARM1: begin
                if (ack_i || other_wr) nxt = ST_RUN;
                else if (ctrl_wr)      nxt = stop_wbit ? ST_ARM1 : ST_ARM10;
            end
            ST_ARM10: begin
                if (ack_i || other_wr) nxt = ST_RUN;
                else if (ctrl_wr)      nxt = stop_wbit ? ST_STOPPED : ST_RUN;
            end
            ST_STOPPED: begin
                if (nmi_rise || line_wake) nxt = ST_RUN;
            end
            default: nxt = ST_RUN;
        endcase
    end

    assign enter = (st == ST_ARM10) && (nxt == ST_STOPPED);
    assign leave = (st == ST_STOPPED) && (nxt == ST_RUN);

    // outputs and status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
            exit_q <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            wake_q <= leave;
            if (enter) begin
                stop_q <= 1'b1;
                exit_q <= 1'b0;
            end else if (leave) begin
                exit_q <= 1'b1;
                stop_q <= nmi_rise;
            end else if (ctrl_wr && st != ST_STOPPED) begin
                if (!stop_wbit) stop_q <= 1'b0;
                if (!exit_wbit) exit_q <= 1'b0;
            end
        end
    end

    assign stop_req_o  = (st == ST_STOPPED);
    assign wake_o      = wake_q;
    assign stop_flag_o = stop_q;
    assign exit_flag_o = exit_q;

    p_commit_needs_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_req_o) |-> $past(ctrl_wr && stop_wbit));
    p_ack_blocks_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_req_o && ack_i) |=> !stop_req_o);
    p_wake_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);
    p_nmi_exit_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req_o && nmi_i && !nmi_q) |=> (!stop_req_o && stop_flag_o && exit_flag_o));
    p_commit_clears_exit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_req_o) |-> !exit_flag_o);
endmodule

// File: rtl/wkup_stop_ctrl.sv
module wkup_stop_ctrl
    import wkup_pkg::*;
#(
    parameter int unsigned N_LINES     = 16,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned NBANK      = N_LINES / BANK_W,
    localparam int unsigned AW         = $clog2(3 * NBANK + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] rdata,
    input  logic [N_LINES-1:0] lines_i,
    input  logic              nmi_i,
    input  logic              ack_i,
    output logic              irq_o,
    output logic              stop_req_o,
    output logic              wake_o
);
    localparam logic [AW-1:0] CTRL_A = AW'(3 * NBANK);

    logic [N_LINES-1:0] mask_q, edge_q, pend_q, ev;
    logic mode_q, irqen_q, ctrl_wr, other_wr, stop_flag, exit_flag;

    assign ctrl_wr  = wr_en && (addr == CTRL_A);
    assign other_wr = wr_en && (addr != CTRL_A);

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        wkup_line_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk       (clk),
            .rst_n     (rst_n),
            .line_i    (lines_i[i]),
            .rise_sel_i(edge_q[i]),
            .edge_o    (ev[i])
        );
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[b*BANK_W +: BANK_W] <= '0;
                edge_q[b*BANK_W +: BANK_W] <= '0;
                pend_q[b*BANK_W +: BANK_W] <= '0;
            end else begin
                if (wr_en && addr == AW'(b))
                    mask_q[b*BANK_W +: BANK_W] <= wdata;
                if (wr_en && addr == AW'(NBANK + b))
                    edge_q[b*BANK_W +: BANK_W] <= wdata;
                pend_q[b*BANK_W +: BANK_W] <=
                    (pend_q[b*BANK_W +: BANK_W] &
                     ~((wr_en && addr == AW'(2 * NBANK + b)) ? wdata : '0))
                    | (ev[b*BANK_W +: BANK_W] & mask_q[b*BANK_W +: BANK_W]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= 1'b0;
            irqen_q <= 1'b0;
        end else if (ctrl_wr) begin
            mode_q  <= wdata[CB_MODE];
            irqen_q <= wdata[CB_IRQEN];
        end
    end

    always_comb begin
        rdata = '0;
        for (int b = 0; b < int'(NBANK); b++) begin
            if (addr == AW'(b))             rdata = mask_q[b*BANK_W +: BANK_W];
            if (addr == AW'(NBANK + b))     rdata = edge_q[b*BANK_W +: BANK_W];
            if (addr == AW'(2 * NBANK + b)) rdata = pend_q[b*BANK_W +: BANK_W];
        end
        if (addr == CTRL_A) begin
            rdata[CB_MODE]  = mode_q;
            rdata[CB_IRQEN] = irqen_q;
            rdata[CB_STOP]  = stop_flag;
            rdata[CB_EXIT]  = exit_flag;
        end
    end

    assign irq_o = irqen_q & |(pend_q & mask_q);

    wkup_stop_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .other_wr   (other_wr),
        .stop_wbit  (wdata[CB_STOP]),
        .exit_wbit  (wdata[CB_EXIT]),
        .ack_i      (ack_i),
        .nmi_i      (nmi_i),
        .line_wake  (mode_q & |(ev & mask_q)),
        .stop_req_o (stop_req_o),
        .wake_o     (wake_o),
        .stop_flag_o(stop_flag),
        .exit_flag_o(exit_flag)
    );

    p_pend_needs_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q) & ~$past(mask_q)) == '0));
    p_pend_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!wr_en) |-> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: tb/tb_wkup_stop_ctrl.sv
`timescale 1ns/1ps
module tb_wkup_stop_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] lines = '0;
    logic        nmi = 1'b0;
    logic        ack = 1'b0;
    logic        irq, stop_req, wake;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wkup_stop_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .lines_i(lines), .nmi_i(nmi), .ack_i(ack),
        .irq_o(irq), .stop_req_o(stop_req), .wake_o(wake)
    );

    // {line[3:0], enable, rise_sel, drive_rising, expect_pending}
    localparam logic [7:0] VEC [6] = '{
        {4'd0,  1'b1, 1'b1, 1'b1, 1'b1},
        {4'd9,  1'b1, 1'b0, 1'b0, 1'b1},
        {4'd3,  1'b1, 1'b1, 1'b0, 1'b0},
        {4'd12, 1'b0, 1'b1, 1'b1, 1'b0},
        {4'd15, 1'b1, 1'b0, 1'b1, 1'b0},
        {4'd7,  1'b1, 1'b0, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        logic [7:0] d;
        int wcnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), d);
            chk("R1 register reset", {8'h0, d}, 16'h0);
        end
        chk("R1 outputs reset", {13'h0, irq, stop_req, wake}, 16'h0);

        // vector table: R2, R3, R5
        wr(3'd6, 8'h02);
        foreach (VEC[k]) begin
            logic [3:0] ln;
            logic [15:0] bit1;
            ln = VEC[k][7:4];
            bit1 = 16'h1 << ln;
            wr(3'd0, VEC[k][3] ? bit1[7:0] : 8'h0);
            wr(3'd1, VEC[k][3] ? bit1[15:8] : 8'h0);
            wr(3'd2, VEC[k][2] ? bit1[7:0] : 8'h0);
            wr(3'd3, VEC[k][2] ? bit1[15:8] : 8'h0);
            lines = VEC[k][1] ? 16'h0 : bit1;
            idle(5);
            wr(3'd4, 8'hFF);
            wr(3'd5, 8'hFF);
            @(negedge clk);
            lines = VEC[k][1] ? bit1 : 16'h0;
            idle(5);
            rd(ln[3] ? 3'd5 : 3'd4, d);
            chk("R3 R2 pending per edge/enable", {15'h0, d[ln[2:0]]}, {15'h0, VEC[k][0]});
            chk("R5 irq follows pending", {15'h0, irq}, {15'h0, VEC[k][0]});
        end
        lines = '0;
        idle(5);

        // R4 clear and set-wins
        wr(3'd0, 8'h01); wr(3'd1, 8'h00); wr(3'd2, 8'h01);
        wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
        @(negedge clk); lines[0] = 1'b1;
        idle(5);
        wr(3'd4, 8'hFE);
        rd(3'd4, d);
        chk("R4 write 0 keeps pending", {8'h0, d}, 16'h0001);
        wr(3'd4, 8'h01);
        rd(3'd4, d);
        chk("R4 write 1 clears pending", {8'h0, d}, 16'h0000);
        lines[0] = 1'b0;
        idle(5);
        @(negedge clk); lines[0] = 1'b1;
        @(negedge clk);
        wr(3'd4, 8'h01);
        rd(3'd4, d);
        chk("R4 edge wins over clear", {8'h0, d}, 16'h0001);

        // R5 gating
        wr(3'd6, 8'h00);
        chk("R5 irq off when disabled", {15'h0, irq}, 16'h0);
        wr(3'd6, 8'h02);
        chk("R5 irq on when enabled", {15'h0, irq}, 16'h1);
        wr(3'd0, 8'h00);
        chk("R5 irq off when line disabled", {15'h0, irq}, 16'h0);
        wr(3'd4, 8'hFF);
        lines = '0;
        idle(5);

        // R6 entry, R9 line exit
        wr(3'd0, 8'h04); wr(3'd2, 8'h04); wr(3'd4, 8'hFF);
        wr(3'd6, 8'h05); wr(3'd6, 8'h01); wr(3'd6, 8'h05);
        chk("R6 stop_req after 1,0,1", {15'h0, stop_req}, 16'h1);
        rd(3'd6, d);
        chk("R6 stop flag set", {8'h0, d}, 16'h0005);
        @(negedge clk); lines[2] = 1'b1;
        wcnt = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (wake) wcnt++;
        end
        chk("R9 wake one cycle", 16'(wcnt), 16'd1);
        chk("R9 stop_req dropped", {15'h0, stop_req}, 16'h0);
        rd(3'd6, d);
        chk("R9 flags stop=0 exit=1", {8'h0, d}, 16'h0009);

        // R12 clear by write
        wr(3'd6, 8'h01);
        rd(3'd6, d);
        chk("R12 exit cleared by write 0", {8'h0, d}, 16'h0001);

        // R12 clear by commit (from NMI exit), R10
        wr(3'd6, 8'h05); wr(3'd6, 8'h01); wr(3'd6, 8'h05);
        @(negedge clk); nmi = 1'b1;
        @(negedge clk);
        chk("R10 nmi ends stop", {15'h0, stop_req}, 16'h0);
        rd(3'd6, d);
        chk("R10 flags stop=1 exit=1", {8'h0, d}, 16'h000D);
        idle(2); nmi = 1'b0;
        wr(3'd6, 8'h0D); wr(3'd6, 8'h09); wr(3'd6, 8'h0D);
        rd(3'd6, d);
        chk("R12 commit clears exit", {8'h0, d}, 16'h0005);
        @(negedge clk); nmi = 1'b1;
        idle(2); nmi = 1'b0;
        rd(3'd6, d);
        chk("R10 stop flag held", {8'h0, d[3:2]}, 16'h0003);
        wr(3'd6, 8'h01);
        rd(3'd6, d);
        chk("R10 stop flag cleared by write 0", {8'h0, d}, 16'h0001);

        // R7 abort by acknowledge and by other write
        wr(3'd6, 8'h05);
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        wr(3'd6, 8'h01); wr(3'd6, 8'h05);
        chk("R7 ack aborts", {15'h0, stop_req}, 16'h0);
        rd(3'd6, d);
        chk("R7 flags both 0", {8'h0, d[3:2]}, 16'h0);
        wr(3'd6, 8'h05); wr(3'd2, 8'h04); wr(3'd6, 8'h01); wr(3'd6, 8'h05);
        chk("R7 other write aborts", {15'h0, stop_req}, 16'h0);
        wr(3'd2, 8'h04);

        // R8 wrong order
        wr(3'd6, 8'h05); wr(3'd6, 8'h01); wr(3'd6, 8'h01); wr(3'd6, 8'h05);
        chk("R8 1,0,0,1 rejected", {15'h0, stop_req}, 16'h0);
        wr(3'd2, 8'h04);

        // R11 interrupt mode: lines do not end stop
        wr(3'd4, 8'hFF);
        wr(3'd6, 8'h04); wr(3'd6, 8'h00); wr(3'd6, 8'h04);
        @(negedge clk); lines[2] = 1'b0;
        idle(3);
        @(negedge clk); lines[2] = 1'b1;
        idle(5);
        chk("R11 stop held in interrupt mode", {15'h0, stop_req}, 16'h1);
        rd(3'd4, d);
        chk("R11 pending still set", {15'h0, d[2]}, 16'h1);
        @(negedge clk); nmi = 1'b1;
        idle(2); nmi = 1'b0;
        chk("R11 nmi still exits", {15'h0, stop_req}, 16'h0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule